// File: doc/BRIEF.md
# Oscillator Stabilization Status Counter

This block runs in the high-speed oscillator clock domain and measures how long the oscillator has been running since it was last restarted. It counts oscillator cycles in which the oscillator is marked valid. It reports progress as a five-flag status byte that fills from the top bit downward, like a thermometer. The count stops at a stabilization limit chosen by software. A done flag then tells the clock switch logic that the oscillator may be used.

Three events clear the counter and the status flags: a reset from any source, entry into STOP, and setting the main-oscillator-stop control bit. A clear takes priority over counting in the same cycle. Oscillator start-up time, when the valid input is low, is not counted. When the oscillator is an RC type, a bypass input raises done at once and freezes the count. Software can read the status as a whole byte, or one bit at a time through a bit-select read port.

Top module: `osc_settle_status`

## Requirements
- R1: While `rst` is high at a clock edge, the counter clears. After that edge `status_byte` reads 00H, and `settle_done` is low unless `rc_bypass` is high.
- R2: Flag positions in `status_byte`: bit 7 = 2^11 cycles, bit 6 = 2^13, bit 5 = 2^14, bit 4 = 2^15, bit 3 = 2^16. Bits 2 to 0 always read 0.
- R3: The count is the number of clock edges since the last clear at which `osc_valid` was high, no clear was active, `rc_bypass` was low and the limit had not been reached. A flag reads 1 from the edge at which this count reaches the flag's threshold.
- R4: Flags set in order starting from bit 7 and stay at 1 until a clear. The successive byte values are 80H, C0H, E0H, F0H, F8H.
- R5: `stop_entry` high at an edge clears `status_byte` to 00H and drops `settle_done` after that edge.
- R6: `osc_halt_ctl` high at an edge clears the status in the same way as R5.
- R7: A clear wins over counting. An edge with a clear and `osc_valid` both high leaves the count at 0.
- R8: Edges with `osc_valid` low do not advance the count, so `status_byte` holds.
- R9: `limit_sel` codes 0 to 4 select limits of 2^11, 2^13, 2^14, 2^15 and 2^16 cycles. Codes 5 to 7 select 2^16. The count saturates at the selected limit, so flags above the limit never set.
- R10: `settle_done` is high once the count has reached the selected limit. It stays high until a clear.
- R11: `rc_bypass` high drives `settle_done` high in the same cycle, with no clock edge needed. While it is high the count holds.
- R12: `rd_bit` equals bit `rd_bit_sel` of `status_byte`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed oscillator clock |
| rst | input | 1 | Synchronous active-high clear from any reset source |
| osc_valid | input | 1 | Oscillator is running; the cycle may be counted |
| limit_sel | input | 3 | Stabilization limit code |
| stop_entry | input | 1 | STOP mode entry pulse (clear) |
| osc_halt_ctl | input | 1 | Main-oscillator-stop control bit (clear while 1) |
| rc_bypass | input | 1 | RC oscillator mode; done without counting |
| rd_bit_sel | input | 3 | Bit index for single-bit read |
| status_byte | output | 8 | Thermometer status byte |
| rd_bit | output | 1 | Selected status bit |
| settle_done | output | 1 | Stabilization limit reached, or bypass active |

## Verification
The count register and the status flags change one edge after the stimulus that moves them, so the bench drives each input at the falling edge and compares `status_byte` and `settle_done` 1 ns after the next rising edge. `settle_done` under bypass and `rd_bit` depend only on logic, with no register, so they are compared 1 ns after the falling-edge drive, before any rising edge. The boundary at 2047 and 2048 valid cycles is checked explicitly. A reference count in the bench is compared on every cycle, so every threshold and the saturation point are checked at the exact edge where they occur.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

    localparam int unsigned NUM_FLAGS = 5;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SEL_W     = 3;

    // Per-cycle control decision for the counter.
    typedef struct packed {
        logic clear;
        logic step;
    } cnt_ctl_t;

    // Threshold exponent of flag idx: 11, 13, 14, 15, 16.
    function automatic int unsigned thr_exp(input int unsigned idx);
        return (idx == 0) ? 11 : 12 + idx;
    endfunction

    // Map a select code to a flag index; unused codes use the top flag.
    function automatic int unsigned limit_idx(input logic [SEL_W-1:0] sel);
        return (int'(sel) >= NUM_FLAGS) ? NUM_FLAGS - 1 : int'(sel);
    endfunction

endpackage

// File: rtl/osc_settle_ctl.sv
module osc_settle_ctl
    import osc_settle_pkg::*;
(
    input  logic     rst,
    input  logic     stop_entry,
    input  logic     osc_halt_ctl,
    input  logic     rc_bypass,
    input  logic     osc_valid,
    input  logic     at_limit,
    output cnt_ctl_t ctl
);
    always_comb begin
        ctl.clear = rst | stop_entry | osc_halt_ctl;
        ctl.step  = !ctl.clear && !rc_bypass && osc_valid && !at_limit;
    end
endmodule

// File: rtl/osc_settle_counter.sv
module osc_settle_counter
    import osc_settle_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] limit_val,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    always_ff @(posedge clk) begin
        if (ctl.clear)
            count <= '0;
        else if (ctl.step)
            count <= count + CNT_W'(1);
    end

    assign at_limit = (count >= limit_val);
endmodule

// File: rtl/osc_settle_flags.sv
module osc_settle_flags
    import osc_settle_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic [CNT_W-1:0]     count,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_thr
        localparam logic [CNT_W-1:0] THR = CNT_W'(1) << thr_exp(i);
        assign flags[i] = (count >= THR);
    end
endmodule

// File: rtl/osc_settle_rdport.sv
module osc_settle_rdport
    import osc_settle_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [SEL_W-1:0]     rd_bit_sel,
    output logic [BYTE_W-1:0]    status_byte,
    output logic                 rd_bit
);
    localparam int unsigned PAD_W = BYTE_W - NUM_FLAGS;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_pos
        assign status_byte[BYTE_W-1-i] = flags[i];
    end
    assign status_byte[PAD_W-1:0] = '0;
    assign rd_bit = status_byte[rd_bit_sel];
endmodule

// File: rtl/osc_settle_status.sv
module osc_settle_status
    import osc_settle_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_valid,
    input  logic [SEL_W-1:0]  limit_sel,
    input  logic              stop_entry,
    input  logic              osc_halt_ctl,
    input  logic              rc_bypass,
    input  logic [SEL_W-1:0]  rd_bit_sel,
    output logic [BYTE_W-1:0] status_byte,
    output logic              rd_bit,
    output logic              settle_done
);
    cnt_ctl_t               ctl;
    logic [CNT_W-1:0]       count;
    logic [CNT_W-1:0]       limit_val;
    logic                   at_limit;
    logic [NUM_FLAGS-1:0]   flags;

    assign limit_val = CNT_W'(1) << thr_exp(limit_idx(limit_sel));

    osc_settle_ctl u_ctl (
        .rst          (rst),
        .stop_entry   (stop_entry),
        .osc_halt_ctl (osc_halt_ctl),
        .rc_bypass    (rc_bypass),
        .osc_valid    (osc_valid),
        .at_limit     (at_limit),
        .ctl          (ctl)
    );

    osc_settle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .ctl       (ctl),
        .limit_val (limit_val),
        .count     (count),
        .at_limit  (at_limit)
    );

    osc_settle_flags #(.CNT_W(CNT_W)) u_flags (
        .count (count),
        .flags (flags)
    );

    osc_settle_rdport u_rd (
        .flags       (flags),
        .rd_bit_sel  (rd_bit_sel),
        .status_byte (status_byte),
        .rd_bit      (rd_bit)
    );

    assign settle_done = at_limit | rc_bypass;
endmodule

// File: rtl/osc_settle_status_chk.sv
module osc_settle_status_chk
    import osc_settle_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              osc_valid,
    input logic [SEL_W-1:0]  limit_sel,
    input logic              stop_entry,
    input logic              osc_halt_ctl,
    input logic              rc_bypass,
    input logic [BYTE_W-1:0] status_byte,
    input logic              settle_done
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> status_byte == 8'h00);

    assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
        status_byte[2:0] == 3'b000);

    assert_thermo_R4: assert property (@(posedge clk) disable iff (rst)
        (!status_byte[6] || status_byte[7]) && (!status_byte[5] || status_byte[6]) &&
        (!status_byte[4] || status_byte[5]) && (!status_byte[3] || status_byte[4]));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !stop_entry && !osc_halt_ctl |=>
        ((status_byte & $past(status_byte)) == $past(status_byte)));

    assert_stop_clear_R5: assert property (@(posedge clk) disable iff (rst)
        stop_entry |=> status_byte == 8'h00);

    assert_halt_clear_R6: assert property (@(posedge clk) disable iff (rst)
        osc_halt_ctl |=> status_byte == 8'h00);

    assert_novalid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !osc_valid && !stop_entry && !osc_halt_ctl |=> $stable(status_byte));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        settle_done && !rc_bypass && !stop_entry && !osc_halt_ctl |=>
        settle_done || (limit_sel != $past(limit_sel)));

    assert_bypass_done_R11: assert property (@(posedge clk) disable iff (rst)
        rc_bypass |-> settle_done);
endmodule

bind osc_settle_status osc_settle_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .osc_valid    (osc_valid),
    .limit_sel    (limit_sel),
    .stop_entry   (stop_entry),
    .osc_halt_ctl (osc_halt_ctl),
    .rc_bypass    (rc_bypass),
    .status_byte  (status_byte),
    .settle_done  (settle_done)
);

// File: tb/osc_settle_status_bench.sv
`timescale 1ns/1ps
module osc_settle_status_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_valid = 1'b0;
    logic [2:0] limit_sel = 3'd4;
    logic       stop_entry = 1'b0;
    logic       osc_halt_ctl = 1'b0;
    logic       rc_bypass = 1'b0;
    logic [2:0] rd_bit_sel = 3'd0;
    logic [7:0] status_byte;
    logic       rd_bit;
    logic       settle_done;

    int checks = 0;
    int failures = 0;
    int mc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    osc_settle_status u_osc_settle_status (
        .clk(clk), .rst(rst), .osc_valid(osc_valid), .limit_sel(limit_sel),
        .stop_entry(stop_entry), .osc_halt_ctl(osc_halt_ctl), .rc_bypass(rc_bypass),
        .rd_bit_sel(rd_bit_sel), .status_byte(status_byte), .rd_bit(rd_bit),
        .settle_done(settle_done)
    );

    function automatic int ref_exp(input int i);
        case (i)
            0: return 11;
            1: return 13;
            2: return 14;
            3: return 15;
            default: return 16;
        endcase
    endfunction

    function automatic int ref_lim(input logic [2:0] sel);
        return 1 << ref_exp((sel > 3'd4) ? 4 : int'(sel));
    endfunction

    function automatic logic [7:0] ref_status(input int c);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 5; i++)
            if (c >= (1 << ref_exp(i))) s[7-i] = 1'b1;
        return s;
    endfunction

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at falling edge, check combinational outputs,
    // advance the reference count at the rising edge, check registered outputs.
    task automatic tick(input logic rs, input logic v, input logic st, input logic hl,
                        input logic bp, input string tag);
        logic [7:0] es;
        @(negedge clk);
        rst = rs; osc_valid = v; stop_entry = st; osc_halt_ctl = hl; rc_bypass = bp;
        rd_bit_sel = 3'($urandom % 8);
        #1;
        es = ref_status(mc);
        chk1("R12 bit read", rd_bit, es[rd_bit_sel]);
        if (!rs) chk1({tag, " R11 done before edge"}, settle_done, (mc >= ref_lim(limit_sel)) | bp);
        @(posedge clk);
        if (rs || st || hl) mc = 0;
        else if (!bp && v && mc < ref_lim(limit_sel)) mc++;
        #1;
        chk8({tag, " status"}, status_byte, ref_status(mc));
        chk1({tag, " R10 done"}, settle_done, (mc >= ref_lim(limit_sel)) | bp);
    endtask

    task automatic run(input int n, input int pct, input string tag);
        for (int k = 0; k < n; k++)
            tick(1'b0, 1'(($urandom % 100) < pct), 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        for (int k = 0; k < 3; k++) tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 reset");
        chk8("R1 status after reset", status_byte, 8'h00);
        chk1("R1 done after reset", settle_done, 1'b0);

        // R3/R4/R2: full run to 2^16 with code 4
        limit_sel = 3'd4;
        run(2047, 100, "R3");
        chk8("R3 one before 2^11", status_byte, 8'h00);
        run(1, 100, "R3");
        chk8("R4 first flag", status_byte, 8'h80);
        run(8192 - 2048, 100, "R4");
        chk8("R4 second flag", status_byte, 8'hC0);
        run(65536 - 8192 + 20, 100, "R4");
        chk8("R2 full byte", status_byte, 8'hF8);
        chk1("R10 done at 2^16", settle_done, 1'b1);
        run(30, 0, "R8");

        // R5: STOP entry clear
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 stop");
        chk8("R5 cleared", status_byte, 8'h00);
        chk1("R5 done dropped", settle_done, 1'b0);

        // R9/R8: limit 2^11 with random valid gaps
        limit_sel = 3'd0;
        run(4000, 60, "R9 lim0");
        chk8("R9 only first flag", status_byte, 8'h80);
        chk1("R9 done lim0", settle_done, 1'b1);

        // R6: main-oscillator-stop bit clear
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 halt");
        chk8("R6 cleared", status_byte, 8'h00);

        // R9: limit 2^13
        limit_sel = 3'd1;
        run(12000, 80, "R9 lim1");
        chk8("R9 two flags", status_byte, 8'hC0);

        // R7: clear with valid in same cycle
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        chk8("R7 clear wins", status_byte, 8'h00);
        run(100, 100, "R7");
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        chk1("R7 count restarted", settle_done, 1'b0);

        // R9: unused code behaves as 2^16 (no done at 2^15)
        limit_sel = 3'd6;
        run(33000, 100, "R9 code6");
        chk8("R9 code6 four flags", status_byte, 8'hF0);
        chk1("R9 code6 not done", settle_done, 1'b0);

        // R11: bypass raises done immediately and freezes the count
        @(negedge clk);
        rc_bypass = 1'b1; osc_valid = 1'b1;
        #1 chk1("R11 immediate done", settle_done, 1'b1);
        for (int k = 0; k < 50; k++) tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11 bypass");
        chk8("R11 count frozen", status_byte, 8'hF0);
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 release");
        chk1("R11 done after release", settle_done, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule